// File: doc/BRIEF.md
# Display Pixel Wire-Format Packer

This block takes a stream of true-colour pixels, each with three 8-bit components in red, green, blue order, and turns it into the byte sequence that a display controller expects on a serial command/data link. Each component is cut down to the depth of the selected wire format by keeping its most significant bits. Red and blue can trade places, and the result is packed into bytes in the order they go on the wire. Depending on the format, one byte carries two pixels, two bytes carry one pixel, or three bytes carry one pixel.

Pixels arrive on a valid/ready handshake with an end-of-frame marker. Bytes leave on a valid/ready handshake with a flag that marks them as pixel data rather than command bytes. Serial shifting, command sequencing and panel timing are handled elsewhere.

Software writes a format code at any time. The packer holds the write and only applies it while it is idle between frames, so a frame is never packed in two formats.

Top module: `pixel_wire_packer`

## Requirements
- R1: The format code `cfgFormat` selects one of eight layouts. Codes 0/1 are 3-bit option A (two bits of zero padding at the top). Codes 2/3 are 3-bit option B (one zero pad bit ahead of each pixel group). Codes 4/5 are 16-bit. Codes 6/7 are 18-bit. Bit 0 set means blue and red positions are exchanged. A write takes place when `cfgWrite` is high at a clock edge.
- R2: After reset, `byteValid` is 0 and `pixReady` is 1. Until a format is written, pixels are packed in code 4 (16-bit, red first).
- R3: In codes 4/5 each pixel gives two bytes, high byte first. The 16-bit word is the top 5 bits of the first component, then the top 6 bits of green, then the top 5 bits of the last component.
- R4: In codes 6/7 each pixel gives three bytes in the order first component, green, last component. Each byte holds the top 6 bits of its component in bits 7:2, and bits 1:0 are zero.
- R5: In codes 0/1 each byte is {2'b00, group of earlier pixel, group of later pixel}. A group is {first MSB, green MSB, last MSB}.
- R6: In codes 2/3 each byte is {1'b0, group of earlier pixel, 1'b0, group of later pixel}.
- R7: In the odd codes the first component is blue and the last is red. In the even codes the first is red and the last is blue.
- R8: If a frame in codes 0..3 ends on an odd pixel count, its last pixel is emitted alone in the upper group, and every bit below it is zero.
- R9: While any byte of the current pixel or pair is still pending, `pixReady` is 0. A byte offered but not taken keeps `byteValid` high and `byteData` unchanged.
- R10: A format written while a frame is in progress, or while its bytes are still draining, does not affect that frame. It applies from the next frame.
- R11: `byteIsData` is 1 with every byte offered on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrite | input | 1 | Format write strobe |
| cfgFormat | input | 3 | Format code (R1) |
| pixValid | input | 1 | Pixel offered |
| pixReady | output | 1 | Pixel accepted when high with pixValid |
| pixData | input | 24 | Pixel, red in 23:16, green 15:8, blue 7:0 |
| pixLast | input | 1 | Pixel is the last of its frame |
| byteValid | output | 1 | Byte offered |
| byteReady | input | 1 | Byte taken when high with byteValid |
| byteData | output | 8 | Wire byte, bit 7 sent first |
| byteIsData | output | 1 | Marks the byte as pixel data |

## Verification
The bench aims at frames of odd length in both 3-bit layouts. A packer that forgets to flush would drop the last pixel, and one that flushes badly would leak stale bits from the previous pair into the lower group. It writes a new format in the middle of a frame. A design that applies the write at once would switch layout partway through, and the byte count and contents would show it. Random backpressure stalls the output on every byte position, so a design that accepted a pixel too early or shifted while stalled would lose or reorder bytes. Mixing red-first and blue-first codes exposes a swap that is applied to the wrong field or only to some layouts.

// File: rtl/pk_pkg.sv
package pk_pkg;
  typedef enum logic [2:0] {
    LD_NONE,
    LD_HALF,
    LD_PAIR,
    LD_SOLO,
    LD_WIDE
  } ldKind_e;

  localparam logic [2:0] FMT_RESET = 3'd4;

  typedef struct packed {
    ldKind_e    kind;
    logic       shift;
    logic [2:0] fmt;
  } pkCtl_t;
endpackage

// File: rtl/pk_ctrl.sv
module pk_ctrl
  import pk_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgWrite,
  input  logic [2:0] cfgFormat,
  input  logic       pixValid,
  input  logic       pixLast,
  input  logic       byteReady,
  output logic       pixReady,
  output logic       byteValid,
  output logic       inFrame,
  output logic [2:0] activeFmt,
  output pkCtl_t     ctl
);
  logic [2:0] pendFmt;
  logic [1:0] cnt;
  logic       halfPending;
  logic       idle;
  logic [2:0] useFmt;
  logic       accept;
  ldKind_e    kind;

  assign idle      = !inFrame && (cnt == 2'd0);
  assign useFmt    = idle ? pendFmt : activeFmt;
  assign pixReady  = (cnt == 2'd0);
  assign byteValid = (cnt != 2'd0);
  assign accept    = pixValid && pixReady;

  always_comb begin
    kind = LD_NONE;
    if (accept) begin
      if (!useFmt[2]) begin
        if (halfPending)  kind = LD_PAIR;
        else if (pixLast) kind = LD_SOLO;
        else              kind = LD_HALF;
      end else begin
        kind = LD_WIDE;
      end
    end
  end

  assign ctl.kind  = kind;
  assign ctl.shift = byteValid && byteReady;
  assign ctl.fmt   = useFmt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendFmt     <= FMT_RESET;
      activeFmt   <= FMT_RESET;
      cnt         <= '0;
      halfPending <= 1'b0;
      inFrame     <= 1'b0;
    end else begin
      if (cfgWrite) pendFmt <= cfgFormat;
      activeFmt <= useFmt;
      if (useFmt != activeFmt) halfPending <= 1'b0;
      unique case (kind)
        LD_HALF: begin cnt <= 2'd0; halfPending <= 1'b1; end
        LD_PAIR,
        LD_SOLO: begin cnt <= 2'd1; halfPending <= 1'b0; end
        LD_WIDE: cnt <= useFmt[1] ? 2'd3 : 2'd2;
        default: if (ctl.shift) cnt <= cnt - 2'd1;
      endcase
      if (accept) inFrame <= !pixLast;
    end
  end
endmodule

// File: rtl/pk_datapath.sv
module pk_datapath
  import pk_pkg::*;
#(
  parameter int CompW = 8,
  localparam int PixW = 3 * CompW
) (
  input  logic            clk,
  input  logic            rstN,
  input  pkCtl_t          ctl,
  input  logic [PixW-1:0] pixData,
  output logic [7:0]      byteData
);
  localparam int ShW = 24;

  logic [CompW-1:0] redC, grnC, bluC, firstC, lastC;
  logic [2:0]       grp, halfGrp;
  logic [7:0]       pairByte, soloByte;
  logic [15:0]      word16;
  logic [23:0]      word18;
  logic [ShW-1:0]   shreg;

  assign redC   = pixData[PixW-1 -: CompW];
  assign grnC   = pixData[2*CompW-1 -: CompW];
  assign bluC   = pixData[CompW-1:0];
  assign firstC = ctl.fmt[0] ? bluC : redC;
  assign lastC  = ctl.fmt[0] ? redC : bluC;
  assign grp    = {firstC[CompW-1], grnC[CompW-1], lastC[CompW-1]};

  always_comb begin
    if (ctl.fmt[1]) begin
      pairByte = {1'b0, halfGrp, 1'b0, grp};
      soloByte = {1'b0, grp, 4'b0000};
    end else begin
      pairByte = {2'b00, halfGrp, grp};
      soloByte = {2'b00, grp, 3'b000};
    end
  end

  assign word16 = {firstC[CompW-1 -: 5], grnC[CompW-1 -: 6], lastC[CompW-1 -: 5]};
  assign word18 = {firstC[CompW-1 -: 6], 2'b00, grnC[CompW-1 -: 6], 2'b00,
                   lastC[CompW-1 -: 6], 2'b00};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shreg   <= '0;
      halfGrp <= '0;
    end else begin
      unique case (ctl.kind)
        LD_HALF: halfGrp <= grp;
        LD_PAIR: shreg   <= {pairByte, 16'h0000};
        LD_SOLO: shreg   <= {soloByte, 16'h0000};
        LD_WIDE: shreg   <= ctl.fmt[1] ? word18 : {word16, 8'h00};
        default: if (ctl.shift) shreg <= {shreg[ShW-9:0], 8'h00};
      endcase
    end
  end

  assign byteData = shreg[ShW-1 -: 8];
endmodule

// File: rtl/pixel_wire_packer.sv
module pixel_wire_packer
  import pk_pkg::*;
#(
  parameter int CompW = 8,
  localparam int PixW = 3 * CompW
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            cfgWrite,
  input  logic [2:0]      cfgFormat,
  input  logic            pixValid,
  output logic            pixReady,
  input  logic [PixW-1:0] pixData,
  input  logic            pixLast,
  output logic            byteValid,
  input  logic            byteReady,
  output logic [7:0]      byteData,
  output logic            byteIsData
);
  pkCtl_t     ctl;
  logic       inFrame;
  logic [2:0] activeFmt;

  pk_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .cfgWrite(cfgWrite), .cfgFormat(cfgFormat),
    .pixValid(pixValid), .pixLast(pixLast), .byteReady(byteReady),
    .pixReady(pixReady), .byteValid(byteValid), .inFrame(inFrame),
    .activeFmt(activeFmt), .ctl(ctl)
  );

  pk_datapath #(.CompW(CompW)) i_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .pixData(pixData), .byteData(byteData)
  );

  assign byteIsData = byteValid;
endmodule

// File: rtl/pk_checker.sv
module pk_checker (
  input logic       clk,
  input logic       rstN,
  input logic       byteValid,
  input logic       byteReady,
  input logic [7:0] byteData,
  input logic       pixReady,
  input logic [2:0] activeFmt,
  input logic       inFrame
);
  p_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    byteValid && !byteReady |=> byteValid && $stable(byteData));

  p_busy_block_r9: assert property (@(posedge clk) disable iff (!rstN)
    byteValid |-> !pixReady);

  p_pad_opt_a_r5: assert property (@(posedge clk) disable iff (!rstN)
    byteValid && (activeFmt[2:1] == 2'b00) |-> (byteData[7:6] == 2'b00));

  p_pad_opt_b_r6: assert property (@(posedge clk) disable iff (!rstN)
    byteValid && (activeFmt[2:1] == 2'b01) |-> (!byteData[7] && !byteData[3]));

  p_pad_18_r4: assert property (@(posedge clk) disable iff (!rstN)
    byteValid && (activeFmt[2:1] == 2'b11) |-> (byteData[1:0] == 2'b00));

  p_fmt_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    inFrame |=> $stable(activeFmt));
endmodule

bind pixel_wire_packer pk_checker i_chk (
  .clk(clk), .rstN(rstN), .byteValid(byteValid), .byteReady(byteReady),
  .byteData(byteData), .pixReady(pixReady), .activeFmt(activeFmt),
  .inFrame(inFrame)
);

// File: tb/test_pixel_wire_packer.sv
module test_pixel_wire_packer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrite = 1'b0;
  logic [2:0]  cfgFormat = 3'd0;
  logic        pixValid = 1'b0;
  logic        pixReady;
  logic [23:0] pixData = '0;
  logic        pixLast = 1'b0;
  logic        byteValid;
  logic        byteReady = 1'b0;
  logic [7:0]  byteData;
  logic        byteIsData;

  int checks = 0;
  int failures = 0;
  int readyPct = 100;
  logic [7:0] expQ[$];
  string      tagQ[$];
  logic       prevStall = 1'b0;
  logic [7:0] prevByte = '0;

  always #2 clk = ~clk;

  pixel_wire_packer i_pixel_wire_packer (
    .clk(clk), .rstN(rstN), .cfgWrite(cfgWrite), .cfgFormat(cfgFormat),
    .pixValid(pixValid), .pixReady(pixReady), .pixData(pixData),
    .pixLast(pixLast), .byteValid(byteValid), .byteReady(byteReady),
    .byteData(byteData), .byteIsData(byteIsData)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] grpOf(input logic [23:0] p, input bit bgr);
    logic [7:0] r = p[23:16], g = p[15:8], b = p[7:0];
    return bgr ? {b[7], g[7], r[7]} : {r[7], g[7], b[7]};
  endfunction

  function automatic string tagOf(input logic [2:0] f);
    if (f[0]) return "R7";
    case (f[2:1])
      2'b00: return "R5";
      2'b01: return "R6";
      2'b10: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic pushExp(input logic [7:0] v, input string tag);
    expQ.push_back(v);
    tagQ.push_back(tag);
  endtask

  // Output side: random backpressure, stall stability and byte compare.
  always @(negedge clk) begin
    if (rstN) begin
      if (prevStall) begin
        chk(byteValid === 1'b1 && byteData === prevByte, "R9 stall hold",
            byteData, prevByte);
      end
      byteReady = ($urandom_range(99) < readyPct);
      if (byteValid) begin
        chk(byteIsData === 1'b1, "R11", byteIsData, 1);
        chk(pixReady === 1'b0, "R9 busy", pixReady, 0);
      end
      prevStall = byteValid && !byteReady;
      prevByte  = byteData;
      if (byteValid && byteReady) begin
        if (expQ.size() == 0) begin
          chk(1'b0, "R1 extra byte", byteData, 0);
        end else begin
          logic [7:0] e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          chk(byteData === e, t, byteData, e);
        end
      end
    end
  end

  task automatic setFmt(input logic [2:0] f);
    @(negedge clk);
    cfgWrite = 1'b1;
    cfgFormat = f;
    @(negedge clk);
    cfgWrite = 1'b0;
  endtask

  task automatic sendPix(input logic [23:0] d, input bit last);
    @(negedge clk);
    pixValid = 1'b1;
    pixData = d;
    pixLast = last;
    while (!pixReady) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    pixValid = 1'b0;
    pixLast = 1'b0;
  endtask

  // Send a frame in format f, optionally writing newFmt after pixel midIdx.
  task automatic runFrame(input logic [2:0] f, input int n, input string force_tag,
                          input int midIdx, input logic [2:0] newFmt);
    logic [23:0] px[$];
    for (int i = 0; i < n; i++) px.push_back(24'($urandom()));
    for (int i = 0; i < n; i++) begin
      string t;
      t = (force_tag != "") ? force_tag : tagOf(f);
      if (!f[2]) begin
        if (i % 2 == 1) begin
          if (f[1]) pushExp({1'b0, grpOf(px[i-1], f[0]), 1'b0, grpOf(px[i], f[0])}, t);
          else      pushExp({2'b00, grpOf(px[i-1], f[0]), grpOf(px[i], f[0])}, t);
        end else if (i == n - 1) begin
          if (f[1]) pushExp({1'b0, grpOf(px[i], f[0]), 4'h0}, "R8");
          else      pushExp({2'b00, grpOf(px[i], f[0]), 3'h0}, "R8");
        end
      end else begin
        logic [7:0] a, g, c;
        a = f[0] ? px[i][7:0] : px[i][23:16];
        g = px[i][15:8];
        c = f[0] ? px[i][23:16] : px[i][7:0];
        if (f[1]) begin
          pushExp({a[7:2], 2'b00}, t);
          pushExp({g[7:2], 2'b00}, t);
          pushExp({c[7:2], 2'b00}, t);
        end else begin
          pushExp({a[7:3], g[7:5]}, t);
          pushExp({g[4:2], c[7:3]}, t);
        end
      end
    end
    for (int i = 0; i < n; i++) begin
      if (($urandom_range(3) == 0)) @(negedge clk);
      sendPix(px[i], i == n - 1);
      if (i == midIdx) setFmt(newFmt);
    end
    while (expQ.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    fork
      begin
        repeat (4) @(negedge clk);
        chk(byteValid === 1'b0, "R2 reset valid", byteValid, 0);
        rstN = 1'b1;
        @(negedge clk);
        chk(byteValid === 1'b0, "R2 idle valid", byteValid, 0);
        chk(pixReady === 1'b1, "R2 idle ready", pixReady, 1);
        // Default format 4 without any write (R2)
        runFrame(3'd4, 1, "R2", -1, 3'd0);
        // Directed: every code, odd and even lengths (R1, R8)
        for (int f = 0; f < 8; f++) begin
          setFmt(3'(f));
          runFrame(3'(f), 3, "", -1, 3'd0);
          runFrame(3'(f), 4, "", -1, 3'd0);
        end
        // Single-pixel frames in 3-bit layouts (R8)
        setFmt(3'd2); runFrame(3'd2, 1, "", -1, 3'd0);
        setFmt(3'd1); runFrame(3'd1, 1, "", -1, 3'd0);
        // Mid-frame write must not take effect until next frame (R10)
        setFmt(3'd4);
        runFrame(3'd4, 5, "R10", 1, 3'd6);
        runFrame(3'd6, 2, "R10", 0, 3'd3);
        runFrame(3'd3, 3, "R10", -1, 3'd0);
        // Random frames with backpressure
        for (int k = 0; k < 40; k++) begin
          logic [2:0] f;
          f = 3'($urandom_range(7));
          readyPct = 30 + $urandom_range(70);
          setFmt(f);
          runFrame(f, 1 + $urandom_range(8), "", -1, 3'd0);
        end
        chk(expQ.size() == 0, "R1 drained", expQ.size(), 0);
      end
      begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule